// File: doc/BRIEF.md
# Banked Parallel-Access Element Memory

This block stores N elements of W bits each and gives F request ports that may all act in the same clock cycle. Each port carries its own element address, a write flag and write data. Every element address is turned into a lane and a row by one of three fixed layouts, chosen by a parameter. In the interleaved layout neighbouring elements fall into neighbouring lanes. In the segmented layout each lane holds an unbroken run of elements. In the per-element layout every element has its own register. The layout decides which requests may proceed together.

A second parameter selects between two storage shapes. In the split shape every lane is an independent single-port store, so ports whose lanes differ proceed together. In the packed shape the lanes of one row sit side by side as fields of one wide word held in a single store. In that case, only requests that fall in the same wide word (the word named by the lowest-numbered valid port) proceed together. A write to one field merges into the word and leaves the other fields as they were.

Each request port uses valid/ready. A request takes effect only in a cycle where both are high. A port that loses arbitration sees ready low and must hold its request until it is accepted. Ready does not wait on a port's own valid and is high on an idle port. Read responses come back on a fixed one-cycle schedule, on the response slot of the port that asked. They have no back-pressure. A plain status pin reports that some valid request was held back in the current cycle.

Top module: `pmem_array`

## Requirements
- R1: Interleaved layout: lane = addr mod F, row = addr div F; in the split shape two valid ports conflict when their lanes are equal.
- R2: Segmented layout: lane = addr div (N/F), row = addr mod (N/F); in the split shape two valid ports conflict when their lanes are equal.
- R3: Per-element layout: each element is its own register (lane = addr, single row); valid ports conflict only when their addresses are equal.
- R4: Packed shape: row r is one word of lanes*W bits, with the element of lane k in bits [k*W +: W]; a valid port is accepted only if its row equals the row of the lowest-numbered valid port and no lower valid port has the same address.
- R5: Packed shape: a write replaces only its own W-bit field; the other elements of the word keep their values.
- R6: A valid port that conflicts with a lower-numbered valid port has ready low, the lower port is served, conflict is high in that cycle, and the held-back request changes no stored element and produces no response.
- R7: An idle port (valid low) shows ready high; a request is performed only when valid and ready are both high.
- R8: An accepted read raises rsp_valid for that port exactly one cycle later, with the element in rsp_data bits [p*W +: W] for port p; rsp_valid stays low in other cycles.
- R9: A read returns the value of the last accepted write to that address.
- R10: Reset clears rsp_valid and leaves the stored elements unchanged.
- R11: With no valid request, conflict is low and no response follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | F | Per-port request valid |
| req_ready | output | F | Per-port request ready (low when held back by a conflict) |
| req_write | input | F | Per-port write flag (1 write, 0 read) |
| req_addr | input | F*clog2(N) | Per-port element address, port p in bits [p*clog2(N) +: clog2(N)] |
| req_wdata | input | F*W | Per-port write data, port p in bits [p*W +: W] |
| rsp_valid | output | F | Per-port read response valid, one cycle after acceptance |
| rsp_data | output | F*W | Per-port read data, port p in bits [p*W +: W] |
| conflict | output | 1 | High when some valid request is held back this cycle |

## Verification
One stimulus stream drives five copies of the block: interleaved, segmented and per-element layouts in the split shape, and interleaved and segmented layouts in the packed shape. Because of that, each address pattern yields a different acceptance mask per copy. Unit-stride address groups are accepted in full by the interleaved split copy but serialised in the segmented one. Stride-F groups do the reverse. Repeated addresses separate the per-element layout from the lane-based ones. Mixed-row groups show the packed copies following the lowest valid port's word. Partial-valid patterns, a fully idle cycle, a lone field write followed by a full-word read, and a reset in the middle of the run cover idle ready, merged writes and retention of the stored elements.

// File: rtl/pmem_pkg.sv
package pmem_pkg;

  typedef enum logic [1:0] {
    PM_CYCLIC   = 2'd0,
    PM_BLOCK    = 2'd1,
    PM_COMPLETE = 2'd2
  } pm_layout_e;

  function automatic int pm_lanes(int n, int f, pm_layout_e l);
    return (l == PM_COMPLETE) ? n : f;
  endfunction

  function automatic int pm_rows(int n, int f, pm_layout_e l);
    return (l == PM_COMPLETE) ? 1 : n / f;
  endfunction

  function automatic int pm_idx_w(int v);
    return (v > 1) ? $clog2(v) : 1;
  endfunction

endpackage

// File: rtl/pmem_addr_map.sv
module pmem_addr_map #(
  parameter int N = 16,
  parameter int F = 4,
  parameter pmem_pkg::pm_layout_e LAYOUT = pmem_pkg::PM_CYCLIC,
  parameter int AW = 4,
  parameter int LW = 2,
  parameter int RW = 2
) (
  input  logic [AW-1:0] addr,
  output logic [LW-1:0] lane,
  output logic [RW-1:0] row
);
  localparam int SPAN = N / F;

  generate
    if (LAYOUT == pmem_pkg::PM_CYCLIC) begin : g_cyc
      assign lane = LW'(int'(addr) % F);
      assign row  = RW'(int'(addr) / F);
    end else if (LAYOUT == pmem_pkg::PM_BLOCK) begin : g_blk
      assign lane = LW'(int'(addr) / SPAN);
      assign row  = RW'(int'(addr) % SPAN);
    end else begin : g_cpl
      assign lane = LW'(addr);
      assign row  = '0;
    end
  endgenerate
endmodule

// File: rtl/pmem_arbiter.sv
module pmem_arbiter #(
  parameter int P  = 4,
  parameter int AW = 4,
  parameter int LW = 2,
  parameter int RW = 2,
  parameter bit RESHAPE = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [P-1:0]    valid,
  input  logic [P*AW-1:0] addr,
  input  logic [P*LW-1:0] lane,
  input  logic [P*RW-1:0] row,
  output logic [P-1:0]    grant
);
  logic [RW-1:0] lead_row;
  logic          lead_found;

  always_comb begin
    lead_row   = '0;
    lead_found = 1'b0;
    for (int p = 0; p < P; p++) begin
      if (valid[p] && !lead_found) begin
        lead_row   = row[p*RW +: RW];
        lead_found = 1'b1;
      end
    end
  end

  always_comb begin
    grant = '0;
    for (int j = 0; j < P; j++) begin
      logic ok;
      ok = valid[j];
      for (int i = 0; i < P; i++) begin
        if (i < j && valid[i]) begin
          if (addr[i*AW +: AW] == addr[j*AW +: AW]) ok = 1'b0;
          if (!RESHAPE && lane[i*LW +: LW] == lane[j*LW +: LW]) ok = 1'b0;
        end
      end
      if (RESHAPE && row[j*RW +: RW] != lead_row) ok = 1'b0;
      grant[j] = ok;
    end
  end

  generate
    for (genvar i = 0; i < P; i++) begin : g_pi
      for (genvar j = i + 1; j < P; j++) begin : g_pj
        if (!RESHAPE) begin : g_split
          p_lanes_distinct_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (grant[i] && grant[j]) |-> (lane[i*LW +: LW] != lane[j*LW +: LW]));
        end else begin : g_pack
          p_word_shared_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (grant[i] && grant[j]) |-> ((row[i*RW +: RW] == row[j*RW +: RW]) &&
                                        (addr[i*AW +: AW] != addr[j*AW +: AW])));
        end
      end
    end
  endgenerate
endmodule

// File: rtl/pmem_store.sv
module pmem_store #(
  parameter int P     = 4,
  parameter int W     = 8,
  parameter int LANES = 4,
  parameter int ROWS  = 4,
  parameter int LW    = 2,
  parameter int RW    = 2,
  parameter bit RESHAPE = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [P-1:0]    rd_en,
  input  logic [P-1:0]    wr_en,
  input  logic [P*LW-1:0] lane,
  input  logic [P*RW-1:0] row,
  input  logic [P*W-1:0]  wdata,
  output logic [P-1:0]    rsp_valid,
  output logic [P*W-1:0]  rsp_data
);
  logic [W-1:0] rd_q [P];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid <= '0;
    else        rsp_valid <= rd_en;
  end

  generate
    for (genvar p = 0; p < P; p++) begin : g_out
      assign rsp_data[p*W +: W] = rd_q[p];
    end

    if (!RESHAPE) begin : g_split
      logic [W-1:0] bank_mem [LANES][ROWS];

      always_ff @(posedge clk) begin
        for (int p = 0; p < P; p++) begin
          if (wr_en[p])
            bank_mem[lane[p*LW +: LW]][row[p*RW +: RW]] <= wdata[p*W +: W];
          if (rd_en[p])
            rd_q[p] <= bank_mem[lane[p*LW +: LW]][row[p*RW +: RW]];
        end
      end
    end else begin : g_pack
      logic [LANES*W-1:0] wide_mem [ROWS];
      logic [RW-1:0]      sel_row;
      logic               sel_found;
      logic [LANES*W-1:0] word_rd;
      logic [LANES*W-1:0] word_wr;

      always_comb begin
        sel_row   = '0;
        sel_found = 1'b0;
        for (int p = 0; p < P; p++) begin
          if ((rd_en[p] || wr_en[p]) && !sel_found) begin
            sel_row   = row[p*RW +: RW];
            sel_found = 1'b1;
          end
        end
      end

      assign word_rd = wide_mem[sel_row];

      always_comb begin
        word_wr = word_rd;
        for (int p = 0; p < P; p++) begin
          if (wr_en[p]) word_wr[int'(lane[p*LW +: LW])*W +: W] = wdata[p*W +: W];
        end
      end

      always_ff @(posedge clk) begin
        if (|wr_en) wide_mem[sel_row] <= word_wr;
        for (int p = 0; p < P; p++) begin
          if (rd_en[p]) rd_q[p] <= word_rd[int'(lane[p*LW +: LW])*W +: W];
        end
      end

      for (genvar p = 0; p < P; p++) begin : g_chk
        p_field_same_row_r5: assert property (@(posedge clk) disable iff (!rst_n)
          (wr_en[p] || rd_en[p]) |-> (row[p*RW +: RW] == sel_row));
      end
    end
  endgenerate
endmodule

// File: rtl/pmem_array.sv
module pmem_array #(
  parameter int N = 16,
  parameter int W = 8,
  parameter int F = 4,
  parameter pmem_pkg::pm_layout_e LAYOUT = pmem_pkg::PM_CYCLIC,
  parameter bit RESHAPE = 1'b0,
  localparam int AW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [F-1:0]    req_valid,
  output logic [F-1:0]    req_ready,
  input  logic [F-1:0]    req_write,
  input  logic [F*AW-1:0] req_addr,
  input  logic [F*W-1:0]  req_wdata,
  output logic [F-1:0]    rsp_valid,
  output logic [F*W-1:0]  rsp_data,
  output logic            conflict
);
  localparam int LANES = pmem_pkg::pm_lanes(N, F, LAYOUT);
  localparam int ROWS  = pmem_pkg::pm_rows(N, F, LAYOUT);
  localparam int LW    = pmem_pkg::pm_idx_w(LANES);
  localparam int RW    = pmem_pkg::pm_idx_w(ROWS);

  logic [F*LW-1:0] lane;
  logic [F*RW-1:0] row;
  logic [F-1:0]    grant;

  generate
    for (genvar p = 0; p < F; p++) begin : g_map
      pmem_addr_map #(
        .N(N), .F(F), .LAYOUT(LAYOUT), .AW(AW), .LW(LW), .RW(RW)
      ) u_map (
        .addr(req_addr[p*AW +: AW]),
        .lane(lane[p*LW +: LW]),
        .row (row[p*RW +: RW])
      );
    end
  endgenerate

  pmem_arbiter #(
    .P(F), .AW(AW), .LW(LW), .RW(RW), .RESHAPE(RESHAPE)
  ) u_arb (
    .clk  (clk),
    .rst_n(rst_n),
    .valid(req_valid),
    .addr (req_addr),
    .lane (lane),
    .row  (row),
    .grant(grant)
  );

  assign req_ready = ~req_valid | grant;
  assign conflict  = |(req_valid & ~grant);

  pmem_store #(
    .P(F), .W(W), .LANES(LANES), .ROWS(ROWS), .LW(LW), .RW(RW), .RESHAPE(RESHAPE)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (grant & ~req_write),
    .wr_en    (grant & req_write),
    .lane     (lane),
    .row      (row),
    .wdata    (req_wdata),
    .rsp_valid(rsp_valid),
    .rsp_data (rsp_data)
  );

  p_lead_served_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid[0] |-> req_ready[0]);

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid == '0) |=> (rsp_valid == '0));

  p_idle_no_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid == '0) |-> !conflict);

  generate
    for (genvar p = 0; p < F; p++) begin : g_chk
      p_read_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid[p] && req_ready[p] && !req_write[p]) |=> rsp_valid[p]);
      p_rsp_origin_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid[p] |-> $past(req_valid[p] && req_ready[p] && !req_write[p]));
    end
  endgenerate
endmodule

// File: tb/pmem_array_bench.sv
module pmem_array_bench;
  localparam int N = 16;
  localparam int W = 8;
  localparam int F = 4;
  localparam int AW = 4;
  localparam int NI = 5;

  typedef struct packed {
    logic [3:0]  vld;
    logic [3:0]  wr;
    logic [15:0] addr;
    logic [19:0] rdy;
  } vec_t;

  // rdy nibbles, high to low: packed-segmented, packed-interleaved,
  // per-element, segmented, interleaved; each nibble is ports 3..0
  localparam vec_t VEC [9] = '{
    '{4'hF, 4'h0, 16'h3210, 20'h1FF1F},
    '{4'hF, 4'h0, 16'hC840, 20'hF1FF1},
    '{4'hF, 4'hF, 16'h4765, 20'h1FF1F},
    '{4'hF, 4'hA, 16'hD595, 20'hB1BB1},
    '{4'hA, 4'h8, 16'hE0A0, 20'hF7FF7},
    '{4'h0, 4'h0, 16'h0000, 20'hFFFFF},
    '{4'hF, 4'h3, 16'h3777, 20'h91991},
    '{4'hF, 4'h0, 16'h7654, 20'h1FF1F},
    '{4'hF, 4'h0, 16'hEAD9, 20'h35F35}
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [F-1:0]    req_valid = '0;
  logic [F-1:0]    req_write = '0;
  logic [F*AW-1:0] req_addr = '0;
  logic [F*W-1:0]  req_wdata = '0;

  logic [F-1:0]    rdy_o [NI];
  logic [F-1:0]    rv_o  [NI];
  logic [F*W-1:0]  rd_o  [NI];
  logic            cf_o  [NI];

  logic [W-1:0]    refm [NI][N];
  int checks = 0;
  int errors = 0;
  int stepno = 0;

  always #5 clk = ~clk;

  pmem_array #(.N(N), .W(W), .F(F), .LAYOUT(pmem_pkg::PM_CYCLIC), .RESHAPE(1'b0)) u_pmem_array (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy_o[0]), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rv_o[0]), .rsp_data(rd_o[0]), .conflict(cf_o[0]));
  pmem_array #(.N(N), .W(W), .F(F), .LAYOUT(pmem_pkg::PM_BLOCK), .RESHAPE(1'b0)) u_pmem_array_blk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy_o[1]), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rv_o[1]), .rsp_data(rd_o[1]), .conflict(cf_o[1]));
  pmem_array #(.N(N), .W(W), .F(F), .LAYOUT(pmem_pkg::PM_COMPLETE), .RESHAPE(1'b0)) u_pmem_array_cpl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy_o[2]), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rv_o[2]), .rsp_data(rd_o[2]), .conflict(cf_o[2]));
  pmem_array #(.N(N), .W(W), .F(F), .LAYOUT(pmem_pkg::PM_CYCLIC), .RESHAPE(1'b1)) u_pmem_array_rcyc (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy_o[3]), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rv_o[3]), .rsp_data(rd_o[3]), .conflict(cf_o[3]));
  pmem_array #(.N(N), .W(W), .F(F), .LAYOUT(pmem_pkg::PM_BLOCK), .RESHAPE(1'b1)) u_pmem_array_rblk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy_o[4]), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rv_o[4]), .rsp_data(rd_o[4]), .conflict(cf_o[4]));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic string map_tag(int k);
    case (k)
      0: return "R1 R7";
      1: return "R2 R7";
      2: return "R3 R7";
      default: return "R4 R7";
    endcase
  endfunction

  // one request cycle on all copies, then the response cycle
  task automatic step(input logic [3:0] vld, input logic [3:0] wr, input logic [15:0] addr,
                      input logic [19:0] rdy, input string dtag);
    logic [F-1:0] exp_rv [NI];
    logic [W-1:0] exp_rd [NI][F];
    @(negedge clk);
    stepno++;
    req_valid = vld;
    req_write = wr;
    req_addr  = addr;
    for (int p = 0; p < F; p++) req_wdata[p*W +: W] = {stepno[3:0], 2'b10, 2'(p)};
    #1;
    for (int k = 0; k < NI; k++) begin
      logic [3:0] er;
      er = rdy[k*4 +: 4];
      chk(rdy_o[k] == er, map_tag(k), int'(rdy_o[k]), int'(er));
      chk(cf_o[k] == (|(vld & ~er)), "R6", int'(cf_o[k]), int'(|(vld & ~er)));
      exp_rv[k] = er & vld & ~wr;
      for (int p = 0; p < F; p++) exp_rd[k][p] = refm[k][addr[p*4 +: 4]];
      for (int p = 0; p < F; p++)
        if (er[p] && vld[p] && wr[p]) refm[k][addr[p*4 +: 4]] = req_wdata[p*W +: W];
    end
    @(posedge clk);
    #1;
    req_valid = '0;
    for (int k = 0; k < NI; k++) begin
      chk(rv_o[k] == exp_rv[k], "R8", int'(rv_o[k]), int'(exp_rv[k]));
      for (int p = 0; p < F; p++)
        if (exp_rv[k][p])
          chk(rd_o[k][p*W +: W] == exp_rd[k][p], dtag, int'(rd_o[k][p*W +: W]), int'(exp_rd[k][p]));
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < NI; k++) for (int a = 0; a < N; a++) refm[k][a] = '0;
    repeat (3) @(negedge clk);
    // reset state: no response, idle ports ready, no flag
    for (int k = 0; k < NI; k++) begin
      chk(rv_o[k] == '0, "R10", int'(rv_o[k]), 0);
      chk(rdy_o[k] == 4'hF, "R7", int'(rdy_o[k]), 15);
      chk(cf_o[k] == 1'b0, "R11", int'(cf_o[k]), 0);
    end
    rst_n = 1'b1;

    // fill every element through one port at a time
    for (int a = 0; a < N; a++) begin
      logic [15:0] ad;
      ad = '0;
      ad[(a % F)*4 +: 4] = 4'(a);
      step(4'(1 << (a % F)), 4'(1 << (a % F)), ad, 20'hFFFFF, "R9");
    end

    // table of address patterns
    for (int v = 0; v < 9; v++)
      step(VEC[v].vld, VEC[v].wr, VEC[v].addr, VEC[v].rdy, "R9");

    // R5: lone field write, then the whole word read back on all ports
    step(4'h1, 4'h1, 16'h0002, 20'hFFFFF, "R5");
    step(4'hF, 4'h0, 16'h3210, 20'h1FF1F, "R5");

    // R11: fully idle cycle, no response afterwards
    step(4'h0, 4'h0, 16'h0000, 20'hFFFFF, "R11");

    // R10: reset during a read response, contents retained
    @(negedge clk);
    req_valid = 4'h1;
    req_write = 4'h0;
    req_addr  = 16'h0005;
    @(posedge clk);
    #1;
    req_valid = '0;
    rst_n = 1'b0;
    #1;
    for (int k = 0; k < NI; k++) chk(rv_o[k] == '0, "R10", int'(rv_o[k]), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    step(4'hF, 4'h0, 16'h3210, 20'h1FF1F, "R10");
    step(4'hF, 4'h0, 16'hC840, 20'hF1FF1, "R10");
    step(4'hF, 4'h0, 16'h7654, 20'h1FF1F, "R10");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule